// File: doc/BRIEF.md
# Strand Processing Element Issue Stage

This block is the in-order issue control of one sequential processing element. Its input is a FIFO that holds a single chain of dependent instructions. It takes the head instruction into a register-read stage, where the instruction reads its one general-purpose register (GPR) operand if the scoreboard marks it valid. The instruction then moves into a single issue register. If the operand was not ready, the issue register watches the GPR broadcast bus from the other elements and captures the value when its index appears. The instruction leaves to the functional units together with the element's own accumulator. When a result returns in the same cycle as an issue, that result is bypassed straight onto the accumulator output.

Loads and stores do no address arithmetic. The memory address comes either from the GPR operand or from the accumulator, and the other of the two supplies the store data. Both go straight to the L1 port. A load also checks a local copy of the store-address queue. The queue keeps only the low address bits, and each load carries a tail mark that tells it which stores are older. An L1 miss freezes issue until the miss clears.

Top module: `pe_issue_stage`

## Requirements
- R1: After reset, iss_valid_o, mem_req_o and fifo_pop_o are low and the accumulator reads zero.
- R2: Instruction word layout (bits, MSB first): kind[30:29] (0 ALU, 1 load, 2 store), uses-GPR[28], GPR index[27:22], address-from-GPR[21], writes-accumulator[20], function[19:16], immediate[15:0]. If both stages are empty, an instruction popped at one clock edge issues in the cycle that starts two edges later. Instructions issue in FIFO order, at most one per cycle.
- R3: An instruction that uses no GPR issues with its 16-bit immediate, sign-extended, as the operand.
- R4: An instruction whose GPR is marked ready at the read stage issues with the value read from the GPR port.
- R5: An instruction whose GPR is not ready waits in the issue register, and nothing behind it advances beyond the read stage. It captures the value from a broadcast with a matching index and issues in the next cycle.
- R6: An instruction may issue in the same cycle that the previous result returns. In that case iss_acc_o equals the returning result.
- R7: After an accumulator-writing instruction issues, no later instruction issues before that result returns.
- R8: For memory instructions, the address is the GPR operand when address-from-GPR is set, and the accumulator otherwise. The store data is the other one. mem_we_o is high only for stores.
- R9: While l1_miss_i is high, nothing issues. The held instruction issues once the miss input falls.
- R10: The store queue holds up to SQ_DEPTH stores, and each entry is addressed by its slot tag. A load whose mark covers an older store with an unknown address does not issue.
- R11: A load is blocked by an older known store only if the low SQ_ADDR_W address bits are equal. Stores allocated at or after the load's mark never block it.
- R12: Freeing the oldest store releases a load that was blocked only by that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_valid_i | input | 1 | Strand FIFO holds an instruction |
| fifo_instr_i | input | 31 | Head instruction word |
| fifo_mark_i | input | log2(SQ_DEPTH)+1 | Store-queue tail mark taken when the head was steered |
| fifo_pop_o | output | 1 | Take the head this cycle |
| gpr_rd_idx_o | output | 6 | GPR index read by the read stage |
| gpr_rd_ready_i | input | 1 | Scoreboard: that GPR is valid |
| gpr_rd_data_i | input | DATA_W | GPR value |
| bc_valid_i | input | 1 | GPR broadcast from another element |
| bc_idx_i | input | 6 | Broadcast register index |
| bc_data_i | input | DATA_W | Broadcast value |
| res_valid_i | input | 1 | Functional unit returns an accumulator result |
| res_data_i | input | DATA_W | Result value |
| iss_valid_o | output | 1 | Instruction issues this cycle |
| iss_func_o | output | 4 | Function code |
| iss_opnd_o | output | DATA_W | GPR or immediate operand |
| iss_acc_o | output | DATA_W | Accumulator, with the result bypassed in |
| mem_req_o | output | 1 | L1 access this cycle |
| mem_we_o | output | 1 | Access is a store |
| mem_addr_o | output | DATA_W | L1 address |
| mem_wdata_o | output | DATA_W | Store data |
| l1_miss_i | input | 1 | Outstanding L1 miss |
| sq_alloc_i | input | 1 | Allocate a store at the queue tail |
| sq_set_i | input | 1 | A store address becomes known |
| sq_set_tag_i | input | log2(SQ_DEPTH) | Slot of that store |
| sq_set_addr_i | input | SQ_ADDR_W | Partial address of that store |
| sq_free_i | input | 1 | Oldest store retires |

## Verification
On every cycle, assertions check the following. The issue register holds its instruction until it issues. A waiting operand becomes valid only after a matching broadcast. A pop always fills the read stage. No result returns without one pending, and no second issue happens while a result is still outstanding. The store queue never overflows or underflows. The bench scenarios cover what only end-to-end values can show: operand and accumulator values in an in-order chain, sign extension, the address/data selection of memory instructions, and the order in which instructions leave. They also show the blocking behaviour of the miss input, of unknown or partially matching older stores, and of store retirement, as well as the zero-delay accumulator bypass.

// File: rtl/pe_issue_pkg.sv
`timescale 1ns/100ps
package pe_issue_pkg;
  localparam int GPR_IDX_W = 6;
  localparam int IMM_W     = 16;
  localparam int FUNC_W    = 4;

  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e                kind;
    logic                 use_gpr;
    logic [GPR_IDX_W-1:0] gpr;
    logic                 addr_gpr;
    logic                 wr_acc;
    logic [FUNC_W-1:0]    func;
    logic [IMM_W-1:0]     imm;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/pe_store_queue.sv
`timescale 1ns/100ps
module pe_store_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              set_i,
  input  logic [PTR_W-1:0]  set_tag_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              free_i,
  input  logic [PTR_W:0]    chk_mark_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_block_o
);
  logic [PTR_W:0]    head_q, tail_q, count, span;
  logic [DEPTH-1:0]  known_q, hit;
  logic [ADDR_W-1:0] addr_q [DEPTH];

  // distance of a slot from the oldest entry, in ring order
  function automatic logic [PTR_W:0] slot_age(int unsigned slot, logic [PTR_W:0] head);
    return {1'b0, PTR_W'(slot) - head[PTR_W-1:0]};
  endfunction

  assign count = tail_q - head_q;
  assign span  = chk_mark_i - head_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [PTR_W:0] age;
    assign age    = slot_age(s, head_q);
    assign hit[s] = (age < count) && (age < span) &&
                    (!known_q[s] || (addr_q[s] == chk_addr_i));
  end
  assign chk_block_o = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      known_q <= '0;
      for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
    end else begin
      if (alloc_i) begin
        known_q[tail_q[PTR_W-1:0]] <= 1'b0;
        tail_q <= tail_q + 1'b1;
      end
      if (set_i) begin
        known_q[set_tag_i] <= 1'b1;
        addr_q[set_tag_i]  <= set_addr_i;
      end
      if (free_i) head_q <= head_q + 1'b1;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && (count == (PTR_W+1)'(DEPTH))) |-> free_i);
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    free_i |-> (count != '0));
endmodule

// File: rtl/pe_operand_pipe.sv
`timescale 1ns/100ps
module pe_operand_pipe
  import pe_issue_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MARK_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fifo_valid_i,
  input  instr_t               fifo_instr_i,
  input  logic [MARK_W-1:0]    fifo_mark_i,
  output logic                 fifo_pop_o,
  output logic [GPR_IDX_W-1:0] gpr_rd_idx_o,
  input  logic                 gpr_rd_ready_i,
  input  logic [DATA_W-1:0]    gpr_rd_data_i,
  input  logic                 bc_valid_i,
  input  logic [GPR_IDX_W-1:0] bc_idx_i,
  input  logic [DATA_W-1:0]    bc_data_i,
  input  logic                 advance_i,
  output logic                 ir_valid_o,
  output logic                 ir_ready_o,
  output kind_e                ir_kind_o,
  output logic                 ir_addr_gpr_o,
  output logic                 ir_wr_acc_o,
  output logic [FUNC_W-1:0]    ir_func_o,
  output logic [MARK_W-1:0]    ir_mark_o,
  output logic [DATA_W-1:0]    ir_opnd_o
);
  instr_t              gr_ins_q, ir_ins_q;
  logic [MARK_W-1:0]   gr_mark_q, ir_mark_q;
  logic                gr_valid_q, ir_valid_q, ir_ok_q;
  logic [DATA_W-1:0]   ir_opnd_q, gr_val;
  logic                ir_free, gr_move, gr_ok, bc_hit_gr, bc_hit_ir;

  function automatic logic [DATA_W-1:0] sext_imm(logic [IMM_W-1:0] imm);
    return {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  assign ir_free    = !ir_valid_q || advance_i;
  assign gr_move    = gr_valid_q && ir_free;
  assign fifo_pop_o = fifo_valid_i && (!gr_valid_q || gr_move);
  assign gpr_rd_idx_o = gr_ins_q.gpr;
  assign bc_hit_gr  = bc_valid_i && (bc_idx_i == gr_ins_q.gpr);
  assign bc_hit_ir  = bc_valid_i && (bc_idx_i == ir_ins_q.gpr);
  assign gr_ok      = !gr_ins_q.use_gpr || gpr_rd_ready_i || bc_hit_gr;
  assign gr_val     = !gr_ins_q.use_gpr ? sext_imm(gr_ins_q.imm) :
                      (gpr_rd_ready_i ? gpr_rd_data_i : bc_data_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gr_valid_q <= 1'b0;
      gr_ins_q   <= '0;
      gr_mark_q  <= '0;
    end else if (fifo_pop_o) begin
      gr_valid_q <= 1'b1;
      gr_ins_q   <= fifo_instr_i;
      gr_mark_q  <= fifo_mark_i;
    end else if (gr_move) begin
      gr_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_valid_q <= 1'b0;
      ir_ok_q    <= 1'b0;
      ir_ins_q   <= '0;
      ir_mark_q  <= '0;
      ir_opnd_q  <= '0;
    end else if (gr_move) begin
      ir_valid_q <= 1'b1;
      ir_ok_q    <= gr_ok;
      ir_ins_q   <= gr_ins_q;
      ir_mark_q  <= gr_mark_q;
      ir_opnd_q  <= gr_val;
    end else if (advance_i) begin
      ir_valid_q <= 1'b0;
    end else if (ir_valid_q && !ir_ok_q && bc_hit_ir) begin
      ir_ok_q   <= 1'b1;
      ir_opnd_q <= bc_data_i;
    end
  end

  assign ir_valid_o    = ir_valid_q;
  assign ir_ready_o    = ir_ok_q;
  assign ir_kind_o     = ir_ins_q.kind;
  assign ir_addr_gpr_o = ir_ins_q.addr_gpr;
  assign ir_wr_acc_o   = ir_ins_q.wr_acc;
  assign ir_func_o     = ir_ins_q.func;
  assign ir_mark_o     = ir_mark_q;
  assign ir_opnd_o     = ir_opnd_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_valid_q && !advance_i) |=> (ir_valid_q && $stable(ir_ins_q)));
  assert_wakeup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_valid_q && !ir_ok_q) |=> (ir_ok_q == $past(bc_valid_i && (bc_idx_i == ir_ins_q.gpr))));
  assert_pop_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |=> gr_valid_q);
endmodule

// File: rtl/pe_issue_stage.sv
`timescale 1ns/100ps
module pe_issue_stage
  import pe_issue_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SQ_DEPTH  = 8,
  parameter int SQ_ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fifo_valid_i,
  input  logic [INSTR_W-1:0]          fifo_instr_i,
  input  logic [$clog2(SQ_DEPTH):0]   fifo_mark_i,
  output logic                        fifo_pop_o,
  output logic [GPR_IDX_W-1:0]        gpr_rd_idx_o,
  input  logic                        gpr_rd_ready_i,
  input  logic [DATA_W-1:0]           gpr_rd_data_i,
  input  logic                        bc_valid_i,
  input  logic [GPR_IDX_W-1:0]        bc_idx_i,
  input  logic [DATA_W-1:0]           bc_data_i,
  input  logic                        res_valid_i,
  input  logic [DATA_W-1:0]           res_data_i,
  output logic                        iss_valid_o,
  output logic [FUNC_W-1:0]           iss_func_o,
  output logic [DATA_W-1:0]           iss_opnd_o,
  output logic [DATA_W-1:0]           iss_acc_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [DATA_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        l1_miss_i,
  input  logic                        sq_alloc_i,
  input  logic                        sq_set_i,
  input  logic [$clog2(SQ_DEPTH)-1:0] sq_set_tag_i,
  input  logic [SQ_ADDR_W-1:0]        sq_set_addr_i,
  input  logic                        sq_free_i
);
  localparam int MARK_W = $clog2(SQ_DEPTH) + 1;

  instr_t              fifo_ins;
  logic                ir_valid, ir_ready, ir_addr_gpr, ir_wr_acc;
  kind_e               ir_kind;
  logic [FUNC_W-1:0]   ir_func;
  logic [MARK_W-1:0]   ir_mark;
  logic [DATA_W-1:0]   ir_opnd, acc_q, acc_now, addr_sel, data_sel;
  logic                pend_q, acc_clear, is_load, is_mem, sq_block, fire;

  assign fifo_ins = instr_t'(fifo_instr_i);

  pe_operand_pipe #(.DATA_W(DATA_W), .MARK_W(MARK_W)) opnd_pipe_i (
    .clk, .rst_n,
    .fifo_valid_i, .fifo_instr_i(fifo_ins), .fifo_mark_i, .fifo_pop_o,
    .gpr_rd_idx_o, .gpr_rd_ready_i, .gpr_rd_data_i,
    .bc_valid_i, .bc_idx_i, .bc_data_i,
    .advance_i(fire),
    .ir_valid_o(ir_valid), .ir_ready_o(ir_ready), .ir_kind_o(ir_kind),
    .ir_addr_gpr_o(ir_addr_gpr), .ir_wr_acc_o(ir_wr_acc), .ir_func_o(ir_func),
    .ir_mark_o(ir_mark), .ir_opnd_o(ir_opnd)
  );

  // accumulator bypass: a returning result is usable in the same cycle
  assign acc_now   = res_valid_i ? res_data_i : acc_q;
  assign acc_clear = !pend_q || res_valid_i;
  assign is_load   = (ir_kind == KIND_LOAD);
  assign is_mem    = is_load || (ir_kind == KIND_STORE);
  assign addr_sel  = ir_addr_gpr ? ir_opnd : acc_now;
  assign data_sel  = ir_addr_gpr ? acc_now : ir_opnd;

  pe_store_queue #(.DEPTH(SQ_DEPTH), .ADDR_W(SQ_ADDR_W)) store_q_i (
    .clk, .rst_n,
    .alloc_i(sq_alloc_i), .set_i(sq_set_i), .set_tag_i(sq_set_tag_i),
    .set_addr_i(sq_set_addr_i), .free_i(sq_free_i),
    .chk_mark_i(ir_mark), .chk_addr_i(addr_sel[SQ_ADDR_W-1:0]),
    .chk_block_o(sq_block)
  );

  assign fire = ir_valid && ir_ready && acc_clear && !l1_miss_i &&
                !(is_load && sq_block);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (res_valid_i) acc_q <= res_data_i;
      if (fire && ir_wr_acc) pend_q <= 1'b1;
      else if (res_valid_i)  pend_q <= 1'b0;
    end
  end

  assign iss_valid_o = fire;
  assign iss_func_o  = ir_func;
  assign iss_opnd_o  = ir_opnd;
  assign iss_acc_o   = acc_now;
  assign mem_req_o   = fire && is_mem;
  assign mem_we_o    = fire && (ir_kind == KIND_STORE);
  assign mem_addr_o  = addr_sel;
  assign mem_wdata_o = data_sel;

  assert_result_expected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |-> pend_q);
  assert_acc_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ir_wr_acc) |=> (!iss_valid_o || res_valid_i));
endmodule

// File: tb/pe_issue_stage_tb_top.sv
`timescale 1ns/100ps
module pe_issue_stage_tb_top;
  import pe_issue_pkg::*;
  localparam int DW = 32, SQD = 8, SQA = 12, MW = 4;
  localparam logic [31:0] LD_KEY = 32'h0F0F_0F0F;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fifo_valid_i, fifo_pop_o, gpr_rd_ready_i, bc_valid_i, res_valid_i;
  logic [INSTR_W-1:0] fifo_instr_i;
  logic [MW-1:0] fifo_mark_i;
  logic [GPR_IDX_W-1:0] gpr_rd_idx_o, bc_idx_i;
  logic [DW-1:0] gpr_rd_data_i, bc_data_i, res_data_i, iss_opnd_o, iss_acc_o, mem_addr_o, mem_wdata_o;
  logic iss_valid_o, mem_req_o, mem_we_o, l1_miss_i, sq_alloc_i, sq_set_i, sq_free_i;
  logic [FUNC_W-1:0] iss_func_o;
  logic [MW-2:0] sq_set_tag_i;
  logic [SQA-1:0] sq_set_addr_i;

  pe_issue_stage #(.DATA_W(DW), .SQ_DEPTH(SQD), .SQ_ADDR_W(SQA)) dut_i (
    .clk, .rst_n, .fifo_valid_i, .fifo_instr_i, .fifo_mark_i, .fifo_pop_o,
    .gpr_rd_idx_o, .gpr_rd_ready_i, .gpr_rd_data_i, .bc_valid_i, .bc_idx_i, .bc_data_i,
    .res_valid_i, .res_data_i, .iss_valid_o, .iss_func_o, .iss_opnd_o, .iss_acc_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .l1_miss_i,
    .sq_alloc_i, .sq_set_i, .sq_set_tag_i, .sq_set_addr_i, .sq_free_i);

  // register file model seen by the read port
  logic        rf_ready [64];
  logic [31:0] rf_val   [64];
  assign gpr_rd_ready_i = rf_ready[gpr_rd_idx_o];
  assign gpr_rd_data_i  = rf_val[gpr_rd_idx_o];

  typedef struct {
    logic [3:0] func; logic [31:0] opnd, acc, addr, wdata;
    bit mem, we, wr, ld; string req;
  } exp_t;

  exp_t exq[$];
  logic [MW+INSTR_W-1:0] fq[$];
  int n_chk = 0, n_fail = 0, issue_count = 0, fu_lat = 1, fu_cnt = 0;
  logic [31:0] fu_val = '0, m_acc = '0;
  logic [MW-1:0] sq_tail = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [INSTR_W-1:0] mk(int k, bit ug, int g, bit ag, bit wr, int f, int imm);
    instr_t i;
    i.kind = kind_e'(k); i.use_gpr = ug; i.gpr = GPR_IDX_W'(g); i.addr_gpr = ag;
    i.wr_acc = wr; i.func = FUNC_W'(f); i.imm = IMM_W'(imm);
    return i;
  endfunction

  // driver: pushes the instruction and the scoreboard item it must produce
  task automatic enq(logic [INSTR_W-1:0] w, logic [MW-1:0] mark, logic [31:0] gval, string req);
    instr_t i; exp_t e;
    i = instr_t'(w);
    e.func = i.func; e.req = req;
    e.opnd = i.use_gpr ? gval : {{16{i.imm[15]}}, i.imm};
    e.acc  = m_acc;
    e.addr  = i.addr_gpr ? e.opnd : m_acc;
    e.wdata = i.addr_gpr ? m_acc : e.opnd;
    e.mem = (i.kind != KIND_ALU); e.we = (i.kind == KIND_STORE);
    e.ld = (i.kind == KIND_LOAD); e.wr = i.wr_acc;
    if (i.wr_acc) m_acc = e.ld ? (e.addr ^ LD_KEY) : (m_acc + e.opnd);
    fq.push_back({mark, w});
    exq.push_back(e);
  endtask

  task automatic bcast(int idx, logic [31:0] v, int lat);
    cyc(lat);
    bc_valid_i = 1'b1; bc_idx_i = GPR_IDX_W'(idx); bc_data_i = v;
    cyc(1);
    bc_valid_i = 1'b0; rf_val[idx] = v; rf_ready[idx] = 1'b1;
  endtask

  task automatic sq_op(bit a, bit s, int tag, int addr, bit f);
    sq_alloc_i = a; sq_set_i = s; sq_set_tag_i = (MW-1)'(tag);
    sq_set_addr_i = SQA'(addr); sq_free_i = f;
    if (a) sq_tail = sq_tail + 1'b1;
    cyc(1);
    sq_alloc_i = 0; sq_set_i = 0; sq_free_i = 0;
  endtask

  task automatic wait_cnt(int target);
    for (int t = 0; t < 60 && issue_count < target; t++) cyc(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // FIFO model: pop seen in a cycle removes the head after the next edge
  initial begin
    bit ps;
    fifo_valid_i = 0; fifo_instr_i = '0; fifo_mark_i = '0;
    forever begin
      @(negedge clk); ps = fifo_pop_o;
      @(posedge clk); #1.5;
      if (ps && fq.size() > 0) void'(fq.pop_front());
      fifo_valid_i = (fq.size() > 0);
      if (fq.size() > 0) {fifo_mark_i, fifo_instr_i} = fq[0];
    end
  end

  // functional-unit model and scoreboard monitor
  initial begin
    res_valid_i = 0; res_data_i = '0;
    forever begin
      @(posedge clk); #1;
      res_valid_i = 0;
      if (fu_cnt > 0) begin
        fu_cnt--;
        if (fu_cnt == 0) begin res_valid_i = 1; res_data_i = fu_val; end
      end
      @(negedge clk);
      if (iss_valid_o) begin
        issue_count++;
        if (exq.size() == 0) chk(0, "R2", 1, 0);
        else begin
          exp_t e;
          e = exq.pop_front();
          chk(iss_opnd_o == e.opnd, e.req, iss_opnd_o, e.opnd);
          chk(iss_acc_o == e.acc, e.req, iss_acc_o, e.acc);
          chk(iss_func_o == e.func, e.req, 32'(iss_func_o), 32'(e.func));
          chk(mem_req_o == e.mem, "R8", 32'(mem_req_o), 32'(e.mem));
          if (e.mem) begin
            chk(mem_we_o == e.we, "R8", 32'(mem_we_o), 32'(e.we));
            chk(mem_addr_o == e.addr, "R8", mem_addr_o, e.addr);
            if (e.we) chk(mem_wdata_o == e.wdata, "R8", mem_wdata_o, e.wdata);
          end
          if (e.wr) begin
            fu_cnt = fu_lat;
            fu_val = e.ld ? (mem_addr_o ^ LD_KEY) : (iss_acc_o + iss_opnd_o);
          end
        end
      end else if (mem_req_o) chk(0, "R8", 1, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    for (int i = 0; i < 64; i++) begin rf_ready[i] = 1'b0; rf_val[i] = '0; end
    rst_n = 0; bc_valid_i = 0; bc_idx_i = '0; bc_data_i = '0; l1_miss_i = 0;
    sq_alloc_i = 0; sq_set_i = 0; sq_set_tag_i = '0; sq_set_addr_i = '0; sq_free_i = 0;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(!iss_valid_o, "R1", 32'(iss_valid_o), 0);
    chk(!mem_req_o, "R1", 32'(mem_req_o), 0);
    chk(!fifo_pop_o, "R1", 32'(fifo_pop_o), 0);
    cyc(1);

    // R1/R2/R3/R6: immediate chain with one-cycle results and bypass
    base = issue_count;
    enq(mk(0, 0, 0, 0, 1, 1, 5), '0, '0, "R1");
    enq(mk(0, 0, 0, 0, 1, 2, 16'hFFFD), '0, '0, "R3");
    enq(mk(0, 0, 0, 0, 1, 3, 100), '0, '0, "R6");
    cyc(1); chk(issue_count == base, "R2", issue_count, base);
    cyc(1); chk(issue_count == base, "R2", issue_count, base);
    cyc(1); chk(issue_count == base + 1, "R2", issue_count, base + 1);
    cyc(2); chk(issue_count == base + 3, "R6", issue_count, base + 3);
    cyc(2);

    // R4: ready GPR read at the read stage
    rf_val[7] = 32'd1000; rf_ready[7] = 1'b1;
    base = issue_count;
    enq(mk(0, 1, 7, 0, 1, 4, 0), '0, 32'd1000, "R4");
    wait_cnt(base + 1); chk(issue_count == base + 1, "R4", issue_count, base + 1);
    cyc(2);

    // R5: waiting operand holds the pipe until a broadcast arrives
    base = issue_count;
    enq(mk(0, 1, 9, 0, 1, 5, 0), '0, 32'd777, "R5");
    enq(mk(0, 0, 0, 0, 1, 6, 1), '0, '0, "R5");
    enq(mk(0, 0, 0, 0, 1, 7, 2), '0, '0, "R5");
    cyc(6);
    chk(issue_count == base, "R5", issue_count, base);
    chk(fq.size() == 1, "R5", fq.size(), 1);
    bcast(9, 32'd777, 2);
    wait_cnt(base + 3); chk(issue_count == base + 3, "R5", issue_count, base + 3);
    base = issue_count;
    enq(mk(0, 1, 10, 0, 1, 8, 0), '0, 32'd55, "R5");
    bcast(10, 32'd55, 0);
    wait_cnt(base + 1); chk(issue_count == base + 1, "R5", issue_count, base + 1);
    cyc(2);

    // R9: L1 miss freezes issue
    l1_miss_i = 1;
    base = issue_count;
    enq(mk(0, 0, 0, 0, 1, 9, 3), '0, '0, "R9");
    cyc(6); chk(issue_count == base, "R9", issue_count, base);
    l1_miss_i = 0;
    cyc(3); chk(issue_count == base + 1, "R9", issue_count, base + 1);
    cyc(2);

    // R7: long-latency result holds the next instruction
    fu_lat = 4;
    base = issue_count;
    enq(mk(0, 0, 0, 0, 1, 10, 1), '0, '0, "R7");
    enq(mk(0, 0, 0, 0, 1, 11, 2), '0, '0, "R7");
    wait_cnt(base + 1);
    cyc(2); chk(issue_count == base + 1, "R7", issue_count, base + 1);
    cyc(4); chk(issue_count == base + 2, "R7", issue_count, base + 2);
    cyc(6);
    fu_lat = 1;

    // R8: stores and loads, address from GPR or accumulator
    rf_val[12] = 32'h100; rf_ready[12] = 1'b1;
    base = issue_count;
    enq(mk(2, 1, 12, 1, 0, 12, 0), sq_tail, 32'h100, "R8");
    enq(mk(2, 1, 12, 0, 0, 13, 0), sq_tail, 32'h100, "R8");
    enq(mk(1, 0, 0, 0, 1, 14, 0), sq_tail, '0, "R8");
    wait_cnt(base + 3); chk(issue_count == base + 3, "R8", issue_count, base + 3);
    cyc(3);

    // R10/R11/R12: store-queue disambiguation
    rf_val[13] = 32'h2345; rf_ready[13] = 1'b1;
    sq_op(1, 0, 0, 0, 0);
    base = issue_count;
    enq(mk(1, 1, 13, 1, 1, 15, 0), sq_tail, 32'h2345, "R10");
    cyc(6); chk(issue_count == base, "R10", issue_count, base);
    sq_op(0, 1, 0, 12'h345, 0);
    cyc(4); chk(issue_count == base, "R11", issue_count, base);
    sq_op(0, 0, 0, 0, 1);
    cyc(3); chk(issue_count == base + 1, "R12", issue_count, base + 1);
    cyc(2);
    base = issue_count;
    enq(mk(1, 1, 13, 1, 1, 1, 0), sq_tail, 32'h2345, "R11");
    sq_op(1, 0, 0, 0, 0);
    cyc(4); chk(issue_count == base + 1, "R11", issue_count, base + 1);
    sq_op(0, 1, 1, 12'h111, 0);
    base = issue_count;
    enq(mk(1, 1, 13, 1, 1, 2, 0), sq_tail, 32'h2345, "R11");
    cyc(5); chk(issue_count == base + 1, "R11", issue_count, base + 1);
    sq_op(0, 0, 0, 0, 1);
    cyc(4);
    chk(exq.size() == 0, "R2", exq.size(), 0);
    finish_run();
  end
endmodule